// File: doc/BRIEF.md
# Frame Base Update Interrupt Unit

This unit keeps the frame-buffer start address for a display controller. Software writes a new start address into a staging register at any time during scan-out. The address the scan engine actually uses (the live base) changes only when the timing generator signals the start of a frame and a staged update is outstanding. At that moment the unit copies the staged address across and records a "base taken" event. Page-flip software can therefore wait on that event, knowing the old buffer is no longer being read.

The event is kept in a raw status bit, which is gated by an enable register to give a masked status and a single interrupt line. Software clears events by writing ones to a clear register. Writing back the masked status value it just read clears exactly the events it has seen. All registers sit on a plain single-cycle register bus: a write strobe with address and data, and a combinational read of the addressed register. Neither path has back-pressure. A write completes in the cycle its strobe is high, and the read data follows the address within the same cycle.

Register offsets (bytes): 0x00 staged base (read/write), 0x04 live base (read only), 0x08 enable, 0x0C raw status (read only), 0x10 masked status (read only), 0x14 clear (write only, reads zero). Unmapped offsets read zero. Writes to a read-only offset have no effect. In every status, enable and clear register, bit 0 is the base-taken event and the other bits read zero.

Top module: `fbu_top`

## Requirements
- R1: After reset the staged base, live base, enable and raw status all read zero, and `irq_out` is low.
- R2: A write to offset 0x00 stores the data with its two low bits forced to zero. A read of 0x00 returns that value.
- R3: The live base (`active_base` and offset 0x04) does not change except on a frame-start cycle while a staged update is outstanding. A frame start with no staged update changes neither the live base nor the raw status.
- R4: On a frame-start cycle with an update outstanding, the live base takes the staged value in the following cycle, raw status bit 0 becomes 1, and the outstanding flag clears.
- R5: If a staged write and a frame start fall in the same cycle, the transfer uses the staged value held before that write, and only if an update was already outstanding. The new value stays outstanding for the next frame start.
- R6: Masked status (0x10) equals raw status AND enable. `irq_out` is the OR of the masked status bits.
- R7: Writing a 1 to bit 0 of the clear register (0x14) clears raw bit 0. Writing 0 leaves it unchanged. Writing back the masked value read clears exactly those bits.
- R8: If a clear write and a new base-taken event fall in the same cycle, raw bit 0 ends up set.
- R9: Writing zero to the enable register drives `irq_out` low and masked status to zero, while raw status is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | REG_AW (5) | Byte offset of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the register at `bus_addr` (combinational) |
| frame_start | input | 1 | One-cycle frame-start strobe from the timing generator |
| active_base | output | DATA_W (32) | Live frame base used by the scan engine |
| irq_out | output | 1 | Interrupt request, OR of masked status |

## Verification
The bench builds the unit with its defaults: DATA_W = 32, REG_AW = 5 and IRQ_W = 1. These values make the full address width visible. A staged value with both low bits set shows the alignment masking. All six offsets, plus an unmapped one, can be reached. With a single event bit, the write-back-of-masked-status idiom and the clear/set collision are observed directly on `irq_out`. Frame starts are placed before, with and after staged writes, so that all three orderings of write and transfer occur.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int OFF_STAGED = 'h00;
  localparam int OFF_LIVE   = 'h04;
  localparam int OFF_ENABLE = 'h08;
  localparam int OFF_RAW    = 'h0C;
  localparam int OFF_MASKED = 'h10;
  localparam int OFF_CLEAR  = 'h14;
  localparam int ALIGN_BITS = 2;
  localparam int EVT_TAKEN  = 0;
endpackage

// File: rtl/fbu_base_regs.sv
module fbu_base_regs #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_wr,
  input  logic [ADDR_W-1:0] stage_wdata,
  input  logic              frame_start,
  output logic [ADDR_W-1:0] staged_q,
  output logic [ADDR_W-1:0] live_q,
  output logic              taken
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  logic outstanding_q;

  assign taken = frame_start & outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q      <= '0;
      live_q        <= '0;
      outstanding_q <= 1'b0;
    end else begin
      if (taken)
        live_q <= staged_q;
      if (stage_wr)
        staged_q <= stage_wdata & ~ALIGN_MASK;
      outstanding_q <= stage_wr | (outstanding_q & ~frame_start);
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable(live_q)); // R3

  AST_LIVE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> live_q == $past(staged_q)); // R4

  AST_LIVE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live_q)); // R5
endmodule

// File: rtl/fbu_irq_regs.sv
module fbu_irq_regs #(
  parameter int IRQ_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [IRQ_W-1:0] en_wdata,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] clr_wdata,
  input  logic [IRQ_W-1:0] set_vec,
  output logic [IRQ_W-1:0] en_q,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (en_wr)
      en_q <= en_wdata;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    logic clr_bit;
    assign clr_bit = clr_wr & clr_wdata[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        raw_q[i] <= 1'b0;
      else
        raw_q[i] <= set_vec[i] | (raw_q[i] & ~clr_bit);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> raw_q[i]); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bit && !set_vec[i]) |=> !raw_q[i]); // R7

    AST_RISE_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[i]) |-> $past(set_vec[i])); // R4
  end

  assign masked = raw_q & en_q;
  assign irq    = |masked;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0 && raw_q != '0)); // R6
endmodule

// File: rtl/fbu_rd_mux.sv
module fbu_rd_mux
  import fbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int IRQ_W  = 1
) (
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] staged,
  input  logic [DATA_W-1:0] live,
  input  logic [IRQ_W-1:0]  en,
  input  logic [IRQ_W-1:0]  raw,
  input  logic [IRQ_W-1:0]  masked,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == REG_AW'(OFF_STAGED))      rdata = staged;
    else if (addr == REG_AW'(OFF_LIVE))   rdata = live;
    else if (addr == REG_AW'(OFF_ENABLE)) rdata = DATA_W'(en);
    else if (addr == REG_AW'(OFF_RAW))    rdata = DATA_W'(raw);
    else if (addr == REG_AW'(OFF_MASKED)) rdata = DATA_W'(masked);
  end
endmodule

// File: rtl/fbu_top.sv
module fbu_top
  import fbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int IRQ_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_start,
  output logic [DATA_W-1:0] active_base,
  output logic              irq_out
);
  logic              stage_wr, en_wr, clr_wr, taken;
  logic [DATA_W-1:0] staged_q, live_q;
  logic [IRQ_W-1:0]  en_q, raw_q, masked, set_vec;

  assign stage_wr = bus_wr && bus_addr == REG_AW'(OFF_STAGED);
  assign en_wr    = bus_wr && bus_addr == REG_AW'(OFF_ENABLE);
  assign clr_wr   = bus_wr && bus_addr == REG_AW'(OFF_CLEAR);

  always_comb begin
    set_vec            = '0;
    set_vec[EVT_TAKEN] = taken;
  end

  fbu_base_regs #(.ADDR_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_wr    (stage_wr),
    .stage_wdata (bus_wdata),
    .frame_start (frame_start),
    .staged_q    (staged_q),
    .live_q      (live_q),
    .taken       (taken)
  );

  fbu_irq_regs #(.IRQ_W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_wdata  (bus_wdata[IRQ_W-1:0]),
    .clr_wr    (clr_wr),
    .clr_wdata (bus_wdata[IRQ_W-1:0]),
    .set_vec   (set_vec),
    .en_q      (en_q),
    .raw_q     (raw_q),
    .masked    (masked),
    .irq       (irq_out)
  );

  fbu_rd_mux #(.DATA_W(DATA_W), .REG_AW(REG_AW), .IRQ_W(IRQ_W)) u_rd (
    .addr   (bus_addr),
    .staged (staged_q),
    .live   (live_q),
    .en     (en_q),
    .raw    (raw_q),
    .masked (masked),
    .rdata  (bus_rdata)
  );

  assign active_base = live_q;

  AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && bus_wdata[IRQ_W-1:0] == '0) |=> !irq_out); // R9
endmodule

// File: tb/tb_fbu_top.sv
`timescale 1ns/1ps
module tb_fbu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_start = 1'b0;
  logic [31:0] active_base;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_staged = 0, m_live = 0;
  bit m_out = 0, m_raw = 0, m_en = 0;

  fbu_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .active_base(active_base), .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_staged;
      5'h04: return m_live;
      5'h08: return {31'd0, m_en};
      5'h0C: return {31'd0, m_raw};
      5'h10: return {31'd0, m_raw & m_en};
      default: return 32'd0;
    endcase
  endfunction

  // one clock: drive at negedge, update model at posedge, compare after
  task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit fs);
    bit set;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; frame_start = fs;
    @(posedge clk);
    set = fs && m_out;
    if (set) m_live = m_staged;
    m_out = (wr && a == 5'h00) || (m_out && !fs);
    if (wr && a == 5'h00) m_staged = d & 32'hFFFF_FFFC;
    if (wr && a == 5'h08) m_en = d[0];
    m_raw = set || (m_raw && !(wr && a == 5'h14 && d[0]));
    #1;
    chk("R4 active_base", active_base, m_live);
    chk("R6 irq_out", {31'd0, irq_out}, {31'd0, m_raw & m_en});
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    @(negedge clk);
    bus_wr = 0; frame_start = 0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, model_read(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 5'h00, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1'b1;
    // R1 reset state
    rd("R1 staged", 5'h00); rd("R1 live", 5'h04); rd("R1 enable", 5'h08);
    rd("R1 raw", 5'h0C);
    chk("R1 irq", {31'd0, irq_out}, 32'd0);
    chk("R1 active_base", active_base, 32'd0);
    // R3 frame start with nothing staged
    step(0, 5'h00, 0, 1);
    rd("R3 raw after idle frame", 5'h0C);
    // R2 staged write with low bits set
    step(1, 5'h00, 32'h1234_5677, 0);
    rd("R2 staged aligned", 5'h00);
    chk("R2 aligned value", bus_rdata, 32'h1234_5674);
    idle(3);
    rd("R3 live unchanged", 5'h04);
    // R4 transfer
    step(0, 5'h00, 0, 1);
    rd("R4 live after frame", 5'h04);
    rd("R4 raw set", 5'h0C);
    rd("R6 masked zero when disabled", 5'h10);
    // R6 enable
    step(1, 5'h08, 32'h1, 0);
    rd("R6 masked", 5'h10);
    // R7 clear with zero has no effect
    step(1, 5'h14, 32'h0, 0);
    rd("R7 raw kept", 5'h0C);
    // R7 write back masked value
    rd("R7 masked read", 5'h10);
    step(1, 5'h14, bus_rdata, 0);
    rd("R7 raw cleared", 5'h0C);
    // R3 second frame without staged update
    step(0, 5'h00, 0, 1);
    rd("R3 raw no event", 5'h0C);
    rd("R3 live no change", 5'h04);
    // R5 write coinciding with frame start, update outstanding
    step(1, 5'h00, 32'hAAAA_0000, 0);
    step(1, 5'h00, 32'hBBBB_0003, 1);
    rd("R5 live old staged", 5'h04);
    rd("R5 staged new", 5'h00);
    step(1, 5'h14, 32'h1, 0);
    step(0, 5'h00, 0, 1);
    rd("R5 live takes second", 5'h04);
    // R5 write with frame start, nothing outstanding
    step(1, 5'h14, 32'h1, 0);
    step(1, 5'h00, 32'hCCCC_0010, 1);
    rd("R5 no transfer live", 5'h04);
    rd("R5 no event raw", 5'h0C);
    idle(1);
    // R8 clear and set together
    step(1, 5'h14, 32'h1, 1);
    rd("R8 raw set wins", 5'h0C);
    rd("R8 live", 5'h04);
    // R9 disable all
    step(1, 5'h08, 32'h0, 0);
    chk("R9 irq low", {31'd0, irq_out}, 32'd0);
    rd("R9 masked zero", 5'h10);
    rd("R9 raw kept", 5'h0C);
    rd("R9 unmapped zero", 5'h1C);
    rd("R9 clear reads zero", 5'h14);
    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule